// File: doc/BRIEF.md
# Four-Channel Light Measurement Sequencer

This block is the register-mapped control core of a red/green/blue/clear light-to-digital front end. An upstream serial slave drives a byte-wide register port with one address bus, a write strobe and write data, and reads a combinational read-data bus. Software programs a 4-bit gain (capacitor count) and a 12-bit integration slot count for each channel. It then writes one of two self-clearing trigger bits to start a measurement pass. A sensor pass stores 10-bit readings. An offset pass stores sign-magnitude offset bytes.

During a pass the block walks the four channels in a fixed order. For each channel it holds a conversion request toward an abstract converter port. The request lasts for the programmed number of slots, and every slot lasts `SLOT_CYCLES` clocks. The converter's value is captured on the last request cycle. The results are held in a shadow store and are committed to the readable registers all at once when the pass ends.

A configuration register selects the external clock mode and the trim-offset mode, and holds a sleep request. An external sleep pin, or the sleep bit when it is honoured, freezes the pass in place.

Top module: `light_seq_core`

## Requirements
- R1: After the active-low asynchronous reset, every mapped register reads 0x00, and `busy`, `conv_req` and `sleep_active` are low.
- R2: The gain registers at addresses 2..5 (red, green, blue, clear) read back bits 3:0 with bits 7:4 as zero. The slot registers at 6..13 hold each channel as a low byte at an even address and a high byte at the next odd address; the high byte keeps bits 3:0 as slot bits 11:8 and reads zero above them.
- R3: Writing address 0 with bit 0 set while idle starts a sensor pass, and bit 1 alone starts an offset pass. `busy` is high from the cycle after the write until the pass ends, and then `busy` falls and the trigger bit reads zero. Channels are visited in the order red, green, blue, clear (`conv_chan` 0,1,2,3).
- R4: For each channel, `conv_req` is high for slots×`SLOT_CYCLES` cycles, with `conv_gain` equal to that channel's gain. A slot count of zero counts as one slot.
- R5: A sensor pass stores `conv_data`, sampled on the channel's last request cycle. Channel i's bits 7:0 go to address 64+2i, and bits 9:8 go to bits 1:0 of address 65+2i; bits 7:2 of that high byte read zero.
- R6: The result and offset registers keep their old values for the whole pass and change only on the cycle the pass ends.
- R7: During an offset pass `conv_ofs` is high. `conv_data` is taken as a signed 10-bit value and is stored at 72+i as bit 7 = sign (1 negative) and bits 6:0 = magnitude, with the magnitude saturated at 127.
- R8: A trigger write while `busy` is high is ignored. If both trigger bits are written together, only a sensor pass runs: address 0 reads 0x01 and `conv_ofs` stays low.
- R9: Address 1 holds trim (bit 0), sleep (bit 1) and external clock (bit 2). The sleep bit is stored only when bit 2 is set in the same write, so it always reads zero while the external clock bit is clear.
- R10: While `sleep_pin` is high, or the stored sleep bit is set, `sleep_active` is high and `conv_req` is low. The pass is frozen and then resumes, so the total request cycles are unchanged and the pass lasts exactly as many cycles longer as it was halted.
- R11: Writes to result, offset or unmapped addresses have no effect, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| sleep_pin | input | 1 | External sleep request, active high |
| conv_data | input | 10 | Converter result for the requested channel |
| conv_req | output | 1 | Conversion request, held for the integration window |
| conv_chan | output | 2 | Channel being converted: 0 red, 1 green, 2 blue, 3 clear |
| conv_gain | output | 4 | Gain setting of the current channel |
| conv_ofs | output | 1 | High during an offset pass |
| busy | output | 1 | A pass is in progress |
| ext_clk_sel | output | 1 | External clock mode bit |
| trim_en | output | 1 | Trim-offset mode bit |
| sleep_active | output | 1 | Effective sleep (pin or honoured bit) |

## Verification
On every cycle, assertions check the invariants:
- the sleep bit is never held without the external clock bit;
- no request is issued while asleep;
- the frozen timer keeps its counters;
- the channel index only ever steps up by one within a pass;
- at most one trigger bit is set, and none is set while idle;
- results stay still while a pass runs.

Only the bench's scenarios can show the following:
- the exact request length per channel, including the zero-slot case;
- the byte split and sign-magnitude saturation of stored values;
- priority when both triggers are written together;
- the exact stretch of a pass halted by the pin.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int RES_W  = 10;
    localparam int GAIN_W = 4;
    localparam int SLOT_W = 12;
    localparam int ADDR_W = 7;

    // Register map (result block placement is fixed by the result readers)
    localparam int A_CTRL  = 0;
    localparam int A_CFG   = 1;
    localparam int A_GAIN0 = 2;
    localparam int A_SLOT0 = A_GAIN0 + NCH;
    localparam int A_RES0  = 64;
    localparam int A_OFS0  = A_RES0 + 2 * NCH;

    typedef enum logic {
        PASS_SENSOR = 1'b0,
        PASS_OFFSET = 1'b1
    } pass_kind_e;

    // Signed converter value to sign-magnitude byte, magnitude saturated at 127
    function automatic logic [7:0] to_sign_mag(input logic [RES_W-1:0] v);
        logic [RES_W-1:0] mag;
        mag = v[RES_W-1] ? (~v + RES_W'(1)) : v;
        if (mag > RES_W'(127)) mag = RES_W'(127);
        return {v[RES_W-1], mag[6:0]};
    endfunction

endpackage

// File: rtl/lms_slot_timer.sv
module lms_slot_timer #(
    parameter int SLOT_CYCLES = 4,
    parameter int SLOT_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slots,
    input  logic              en,
    output logic              active,
    output logic              fin
);
    localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(SLOT_CYCLES - 1);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] left;
        logic [CYC_W-1:0]  cyc;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    assign active = tmr_q.active;
    assign fin    = tmr_q.active && en && (tmr_q.cyc == '0) && (tmr_q.left == SLOT_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.active = 1'b1;
            tmr_d.left   = (load_slots == '0) ? SLOT_W'(1) : load_slots;
            tmr_d.cyc    = CYC_MAX;
        end else if (tmr_q.active && en) begin
            if (tmr_q.cyc == '0) begin
                if (tmr_q.left == SLOT_W'(1)) begin
                    tmr_d.active = 1'b0;
                end else begin
                    tmr_d.left = tmr_q.left - SLOT_W'(1);
                    tmr_d.cyc  = CYC_MAX;
                end
            end else begin
                tmr_d.cyc = tmr_q.cyc - CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(tmr_q)); // R10

    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active |-> (tmr_q.left != '0)); // R4

endmodule

// File: rtl/lms_pass_fsm.sv
module lms_pass_fsm
    import lms_pkg::*;
#(
    parameter int SLOT_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  pass_kind_e                   start_kind,
    input  logic                         halt,
    input  logic [NCH-1:0][SLOT_W-1:0]   slots,
    output logic                         busy,
    output pass_kind_e                   kind,
    output logic [CH_W-1:0]              chan,
    output logic                         req,
    output logic                         cap,
    output logic                         done
);
    typedef struct packed {
        logic            busy;
        pass_kind_e      kind;
        logic [CH_W-1:0] chan;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              t_load;
    logic [SLOT_W-1:0] t_slots;
    logic              t_active;
    logic              t_fin;
    logic [CH_W-1:0]   chan_nxt;

    assign chan_nxt = seq_q.chan + CH_W'(1);

    lms_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SLOT_W      (SLOT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (t_load),
        .load_slots (t_slots),
        .en         (!halt),
        .active     (t_active),
        .fin        (t_fin)
    );

    always_comb begin
        seq_d   = seq_q;
        t_load  = 1'b0;
        t_slots = slots[0];
        done    = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.kind = start_kind;
                seq_d.chan = '0;
                t_load     = 1'b1;
            end
        end else if (t_fin) begin
            if (seq_q.chan == CH_W'(NCH - 1)) begin
                seq_d.busy = 1'b0;
                done       = 1'b1;
            end else begin
                seq_d.chan = chan_nxt;
                t_load     = 1'b1;
                t_slots    = slots[chan_nxt];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{busy: 1'b0, kind: PASS_SENSOR, chan: '0};
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign kind = seq_q.kind;
    assign chan = seq_q.chan;
    assign req  = t_active && !halt;
    assign cap  = t_fin;

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy); // R3

    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && $past(seq_q.busy) && (seq_q.chan != $past(seq_q.chan)))
        |-> (seq_q.chan == CH_W'($past(seq_q.chan) + 1'b1))); // R3

endmodule

// File: rtl/light_seq_core.sv
module light_seq_core
    import lms_pkg::*;
#(
    parameter int SLOT_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rd_data,
    input  logic                 sleep_pin,
    input  logic [RES_W-1:0]     conv_data,
    output logic                 conv_req,
    output logic [CH_W-1:0]      conv_chan,
    output logic [GAIN_W-1:0]    conv_gain,
    output logic                 conv_ofs,
    output logic                 busy,
    output logic                 ext_clk_sel,
    output logic                 trim_en,
    output logic                 sleep_active
);
    typedef struct packed {
        logic                        trig_sens;
        logic                        trig_ofs;
        logic                        cfg_trim;
        logic                        cfg_sleep;
        logic                        cfg_ext;
        logic [NCH-1:0][GAIN_W-1:0]  gain;
        logic [NCH-1:0][SLOT_W-1:0]  slots;
        logic [NCH-1:0][RES_W-1:0]   shadow;
        logic [NCH-1:0][RES_W-1:0]   res;
        logic [NCH-1:0][7:0]         ofs;
    } regs_t;

    regs_t r_q, r_d;

    logic       start;
    pass_kind_e start_kind;
    logic       halt;
    logic       seq_busy;
    pass_kind_e seq_kind;
    logic       seq_cap;
    logic       seq_done;

    assign halt       = sleep_pin || r_q.cfg_sleep;
    assign start      = wr_en && (addr == ADDR_W'(A_CTRL)) && !seq_busy && (wdata[0] || wdata[1]);
    assign start_kind = wdata[0] ? PASS_SENSOR : PASS_OFFSET;

    lms_pass_fsm #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .halt       (halt),
        .slots      (r_q.slots),
        .busy       (seq_busy),
        .kind       (seq_kind),
        .chan       (conv_chan),
        .req        (conv_req),
        .cap        (seq_cap),
        .done       (seq_done)
    );

    // Next-state for the register file
    always_comb begin
        r_d = r_q;

        if (start) begin
            r_d.trig_sens = wdata[0];
            r_d.trig_ofs  = !wdata[0];
        end

        if (wr_en) begin
            if (addr == ADDR_W'(A_CFG)) begin
                r_d.cfg_trim  = wdata[0];
                r_d.cfg_ext   = wdata[2];
                r_d.cfg_sleep = wdata[1] && wdata[2];
            end
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(A_GAIN0 + i)) r_d.gain[i] = wdata[GAIN_W-1:0];
                if (addr == ADDR_W'(A_SLOT0 + 2 * i)) r_d.slots[i][7:0] = wdata;
                if (addr == ADDR_W'(A_SLOT0 + 2 * i + 1)) r_d.slots[i][SLOT_W-1:8] = wdata[SLOT_W-9:0];
            end
        end

        if (seq_cap) r_d.shadow[conv_chan] = conv_data;

        if (seq_done) begin
            r_d.trig_sens = 1'b0;
            r_d.trig_ofs  = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                if (seq_kind == PASS_SENSOR) r_d.res[i] = r_d.shadow[i];
                else                         r_d.ofs[i] = to_sign_mag(r_d.shadow[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read mux
    always_comb begin
        rd_data = 8'h00;
        if (addr == ADDR_W'(A_CTRL)) rd_data = {6'b0, r_q.trig_ofs, r_q.trig_sens};
        if (addr == ADDR_W'(A_CFG))  rd_data = {5'b0, r_q.cfg_ext, r_q.cfg_sleep, r_q.cfg_trim};
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(A_GAIN0 + i))        rd_data = {{(8-GAIN_W){1'b0}}, r_q.gain[i]};
            if (addr == ADDR_W'(A_SLOT0 + 2 * i))     rd_data = r_q.slots[i][7:0];
            if (addr == ADDR_W'(A_SLOT0 + 2 * i + 1)) rd_data = {{(16-SLOT_W){1'b0}}, r_q.slots[i][SLOT_W-1:8]};
            if (addr == ADDR_W'(A_RES0 + 2 * i))      rd_data = r_q.res[i][7:0];
            if (addr == ADDR_W'(A_RES0 + 2 * i + 1))  rd_data = {{(16-RES_W){1'b0}}, r_q.res[i][RES_W-1:8]};
            if (addr == ADDR_W'(A_OFS0 + i))          rd_data = r_q.ofs[i];
        end
    end

    assign conv_gain    = r_q.gain[conv_chan];
    assign conv_ofs     = seq_busy && (seq_kind == PASS_OFFSET);
    assign busy         = seq_busy;
    assign ext_clk_sel  = r_q.cfg_ext;
    assign trim_en      = r_q.cfg_trim;
    assign sleep_active = halt;

    AST_SLEEP_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg_sleep |-> r_q.cfg_ext); // R9

    AST_ASLEEP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> !conv_req); // R10

    AST_TRIG_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!r_q.trig_sens && !r_q.trig_ofs)); // R3

    AST_ONE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.trig_sens, r_q.trig_ofs})); // R8

    AST_RESULTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.res) && $stable(r_q.ofs))); // R6

endmodule

// File: tb/tb_light_seq_core.sv
module tb_light_seq_core;

    localparam int SC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       sleep_pin = 1'b0;
    logic [9:0] conv_data;
    logic       conv_req;
    logic [1:0] conv_chan;
    logic [3:0] conv_gain;
    logic       conv_ofs;
    logic       busy;
    logic       ext_clk_sel;
    logic       trim_en;
    logic       sleep_active;

    logic [9:0] model_val [4];
    int         n_checks = 0;
    int         n_fail = 0;
    int         req_cnt [4];
    logic [3:0] gain_seen [4];
    bit         order_ok;
    bit         hold_ok;
    bit         ofs_seen;

    always #10 clk = ~clk;

    assign conv_data = model_val[conv_chan];

    light_seq_core #(.SLOT_CYCLES(SC)) dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
        .rd_data (rd_data), .sleep_pin (sleep_pin), .conv_data (conv_data),
        .conv_req (conv_req), .conv_chan (conv_chan), .conv_gain (conv_gain),
        .conv_ofs (conv_ofs), .busy (busy), .ext_clk_sel (ext_clk_sel),
        .trim_en (trim_en), .sleep_active (sleep_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 7'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        addr = 7'(a);
        #1;
        check(rd_data == 8'(exp), tag, rd_data, exp);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    endtask

    // Observes one pass from the negedge after the trigger edge
    task automatic monitor_pass(input int watch_addr, input int old_val);
        int last_ch;
        for (int i = 0; i < 4; i++) req_cnt[i] = 0;
        order_ok = 1; hold_ok = 1; ofs_seen = 0; last_ch = 0;
        addr = 7'(watch_addr);
        #1;
        for (int n = 0; n < 2000 && busy; n++) begin
            if (conv_req) begin
                req_cnt[conv_chan]++;
                gain_seen[conv_chan] = conv_gain;
                if (conv_ofs) ofs_seen = 1;
            end
            if (!(int'(conv_chan) == last_ch || int'(conv_chan) == last_ch + 1)) order_ok = 0;
            last_ch = int'(conv_chan);
            if (rd_data != 8'(old_val)) hold_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic set_slots(input int c, input int s);
        wr(6 + 2 * c, s & 8'hFF);
        wr(7 + 2 * c, s >> 8);
    endtask

    task automatic t_reset();
        check(busy == 0, "R1 busy", busy, 0);
        check(conv_req == 0, "R1 conv_req", conv_req, 0);
        check(sleep_active == 0, "R1 sleep_active", sleep_active, 0);
        for (int a = 0; a < 14; a++) rd_chk(a, 0, "R1 cfg reg");
        for (int a = 64; a < 76; a++) rd_chk(a, 0, "R1 result reg");
    endtask

    task automatic t_regs();
        wr(2, 8'hFF); rd_chk(2, 8'h0F, "R2 gain upper bits");
        wr(6, 8'hAB); rd_chk(6, 8'hAB, "R2 slot low");
        wr(7, 8'hFF); rd_chk(7, 8'h0F, "R2 slot high upper bits");
        wr(1, 8'h01); rd_chk(1, 8'h01, "R9 trim bit");
        check(trim_en == 1, "R9 trim_en", trim_en, 1);
        wr(1, 8'h00);
    endtask

    task automatic t_sensor();
        int exp_cnt [4] = '{8, 4, 12, 4};
        set_slots(0, 2); set_slots(1, 1); set_slots(2, 3); set_slots(3, 0);
        for (int c = 0; c < 4; c++) wr(2 + c, c + 1);
        model_val[0] = 10'h3A5; model_val[1] = 10'h012;
        model_val[2] = 10'h2FF; model_val[3] = 10'h100;
        wr(0, 8'h01);
        check(busy == 1, "R3 busy after trigger", busy, 1);
        monitor_pass(64, 0);
        for (int c = 0; c < 4; c++) begin
            check(req_cnt[c] == exp_cnt[c], "R4 request length", req_cnt[c], exp_cnt[c]);
            check(gain_seen[c] == 4'(c + 1), "R4 gain per channel", gain_seen[c], c + 1);
        end
        check(order_ok, "R3 channel order", order_ok, 1);
        check(hold_ok, "R6 result held during pass", hold_ok, 1);
        check(!ofs_seen, "R7 conv_ofs low in sensor pass", ofs_seen, 0);
        rd_chk(0, 0, "R3 trigger self-clear");
        rd_chk(64, 8'hA5, "R5 red low"); rd_chk(65, 8'h03, "R5 red high");
        rd_chk(66, 8'h12, "R5 green low"); rd_chk(67, 8'h00, "R5 green high");
        rd_chk(68, 8'hFF, "R5 blue low"); rd_chk(69, 8'h02, "R5 blue high");
        rd_chk(70, 8'h00, "R5 clear low"); rd_chk(71, 8'h01, "R5 clear high");
    endtask

    task automatic t_offset();
        model_val[0] = 10'd5;   model_val[1] = 10'h3FD;
        model_val[2] = 10'd200; model_val[3] = 10'h200;
        wr(0, 8'h02);
        monitor_pass(72, 0);
        check(ofs_seen, "R7 conv_ofs high", ofs_seen, 1);
        check(hold_ok, "R6 offset held during pass", hold_ok, 1);
        rd_chk(72, 8'h05, "R7 positive");
        rd_chk(73, 8'h83, "R7 negative");
        rd_chk(74, 8'h7F, "R7 positive saturate");
        rd_chk(75, 8'hFF, "R7 negative saturate");
        rd_chk(64, 8'hA5, "R7 sensor results untouched");
        rd_chk(0, 0, "R3 offset trigger self-clear");
    endtask

    task automatic t_busy_trigger();
        model_val[0] = 10'h155; model_val[1] = 10'h2AA;
        model_val[2] = 10'h001; model_val[3] = 10'h3FF;
        wr(0, 8'h03);
        rd_chk(0, 8'h01, "R8 both bits sensor only");
        check(conv_ofs == 0, "R8 conv_ofs low", conv_ofs, 0);
        wr(0, 8'h02);
        rd_chk(0, 8'h01, "R8 trigger while busy ignored");
        wait_idle();
        rd_chk(72, 8'h05, "R8 no offset pass ran");
        rd_chk(75, 8'hFF, "R8 no offset pass ran (clear)");
        rd_chk(64, 8'h55, "R5 red low second pass");
        rd_chk(65, 8'h01, "R5 red high second pass");
        rd_chk(71, 8'h03, "R5 clear high second pass");
    endtask

    task automatic t_pin_halt();
        int total = 0;
        int n = 0;
        bit bad = 0;
        wr(0, 8'h01);
        while (busy && n < 2000) begin
            if (n == 5)  sleep_pin = 1'b1;
            if (n == 15) sleep_pin = 1'b0;
            #1;
            if (sleep_pin && conv_req) bad = 1;
            if (sleep_pin && !sleep_active) bad = 1;
            if (conv_req) total++;
            n++;
            @(negedge clk);
        end
        check(!bad, "R10 no request while pin asleep", bad, 0);
        check(total == 28, "R10 total request cycles", total, 28);
        check(n == 38, "R10 pass stretched by halt", n, 38);
    endtask

    task automatic t_ignored();
        wr(64, 8'hEE); rd_chk(64, 8'h55, "R11 result write ignored");
        wr(72, 8'h77); rd_chk(72, 8'h05, "R11 offset write ignored");
        wr(20, 8'h5A); rd_chk(20, 8'h00, "R11 unmapped reads zero");
        rd_chk(127, 8'h00, "R11 top address reads zero");
    endtask

    task automatic t_sleep_cfg();
        bit bad = 0;
        wr(1, 8'h02); rd_chk(1, 8'h00, "R9 sleep without ext dropped");
        check(sleep_active == 0, "R9 no sleep", sleep_active, 0);
        wr(1, 8'h06); rd_chk(1, 8'h06, "R9 sleep with ext kept");
        check(ext_clk_sel == 1, "R9 ext_clk_sel", ext_clk_sel, 1);
        check(sleep_active == 1, "R10 sleep bit active", sleep_active, 1);
        wr(0, 8'h01);
        for (int n = 0; n < 10; n++) begin
            if (conv_req || !busy) bad = 1;
            @(negedge clk);
        end
        check(!bad, "R10 sleep bit freezes pass", bad, 0);
        wr(1, 8'h04); rd_chk(1, 8'h04, "R9 ext kept, sleep cleared");
        wait_idle();
        check(busy == 0, "R10 pass resumes and ends", busy, 0);
        wr(1, 8'h06); wr(1, 8'h02);
        rd_chk(1, 8'h00, "R9 clearing ext clears sleep");
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 4; c++) model_val[c] = '0;
        #1;
        check(busy == 0 && rd_data == 0, "R1 during reset", busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sensor();
        t_offset();
        t_busy_trigger();
        t_pin_halt();
        t_ignored();
        t_sleep_cfg();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule